// File: doc/BRIEF.md
# Fixed-Point PID Controller with Anti-Windup

This block is a clocked, signed fixed-point PID controller. Each control step it forms a signed deviation from a setpoint and a measured value. It runs that deviation through proportional, integral and filtered-derivative paths and sums the three terms. It then clamps the sum between a programmable lower and upper limit. The result is presented as the control value, with the deviation itself and flags for the limits and the anti-windup hold.

A call-cycle divider spaces the control steps N base ticks apart, and the outputs change only on those steps. The proportional gain is in Q8.8 format. A mode input selects one of two structures. In series form the gain is applied ahead of the integral and derivative paths. In parallel form the gain reaches only the proportional term. A rising edge on the sync input loads the dynamic state, so the output jumps to a chosen value and control carries on smoothly from there.

If the block is disabled, or if its limits are inconsistent, it goes passive. All outputs and all state are then cleared, so the next active step starts with no history.

Top module: `pid_fx_ctrl`

## Requirements
- R1: The deviation is meas minus setp when `direct_i`=1 and setp minus meas when `direct_i`=0, saturated to DW bits. It is registered to `dev_o` on each control step.
- R2: While `en_i`=0 or the error condition holds, every base tick forces `y_o`, `dev_o`, `arw_o`, `at_min_o` and `at_max_o` to 0. It also clears the integral state, the derivative state and the stored previous input, and the pending sync history. Reset gives the same state.
- R3: When `ymin_i` >= `ymax_i` (signed), `err_o`=1 and `err_code_o`=1 from the next clock edge, and the block is passive. Otherwise `err_o`=0 and `err_code_o`=0.
- R4: A control step occurs on the first active tick, then every N ticks, where N=`ncyc_i` and 0 counts as 1. Outputs hold between steps.
- R5: `y_o` = clamp(P+I+D, ymin, ymax). `at_min_o`/`at_max_o` are 1 exactly when the stepped `y_o` equals the lower or upper limit.
- R6: P = sat((kp × dev) >>> 8), an arithmetic shift. With `mode_i`=1 (parallel), the integral and derivative paths take the input u = dev.
- R7: With `mode_i`=0 (series), the integral and derivative paths take u = P.
- R8: Each step the integral state I becomes sat(I + sat((u×N)/Tn)), where the division truncates toward zero. `tn_i`=0 forces I to 0.
- R9: When `tn_i`≠0 and either `at_max_o`=1 with dev>0 or `at_min_o`=1 with dev<0, I keeps its previous value and `arw_o`=1 for that step. Otherwise `arw_o`=0.
- R10: D = sat((Td×Dprev + Tv×(u−uprev))/(Td+N)), where the division truncates. `tv_i`=0 forces D to 0.
- R11: A rising edge of `sync_i`, seen between consecutive steps, makes that step load I := sat(s−P−D), where s = clamp(`sync_val_i`, ymin, ymax). When `tn_i`=0 it loads D := sat(s−P) instead. A held-high sync has no further effect.
- R12: The first step after passive treats u−uprev as 0 and starts from I=0 and D=0. A sync already high when the block is enabled counts as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Controller enable |
| direct_i | input | 1 | 1: direct action, 0: reverse action |
| sync_i | input | 1 | Synchronisation strobe (rising edge acts) |
| sync_val_i | input | DW | Target output for synchronisation |
| setp_i | input | DW | Setpoint, signed |
| meas_i | input | DW | Measured value, signed |
| kp_i | input | GW | Proportional gain, signed Q8.8 |
| tn_i | input | TW | Integral time in steps, 0 disables |
| tv_i | input | TW | Derivative time in steps, 0 disables |
| td_i | input | TW | Derivative damping time in steps |
| ymin_i | input | DW | Lower output limit, signed |
| ymax_i | input | DW | Upper output limit, signed |
| mode_i | input | 1 | 0 series, 1 parallel |
| ncyc_i | input | CW | Call-cycle divider N |
| y_o | output | DW | Limited control value |
| dev_o | output | DW | Signed control deviation |
| arw_o | output | 1 | Anti-windup hold active |
| at_min_o | output | 1 | Output sits at lower limit |
| at_max_o | output | 1 | Output sits at upper limit |
| err_o | output | 1 | Parameter error |
| err_code_o | output | EW | Error code, 1 = limits inconsistent |

## Verification
The bench drives the integrator into the upper limit and holds the deviation positive there. A design that kept integrating would stall when the deviation reverses, and `arw_o` would never rise. It sends sync pulses with targets outside the limits and keeps sync high for several steps. A wrong design would miss the clamp or re-load the state on every step. It re-enables after a passive spell and switches N between 3 and 0. A slip there would show as a derivative kick on the first step, or as outputs moving on ticks that are not steps.

// File: rtl/pid_fx_pkg.sv
package pid_fx_pkg;

    typedef logic signed [63:0] acc_t;

    typedef enum logic {
        MODE_SERIES   = 1'b0,
        MODE_PARALLEL = 1'b1
    } pid_mode_e;

    typedef enum logic [3:0] {
        ERR_NONE   = 4'd0,
        ERR_LIMITS = 4'd1
    } pid_err_e;

    typedef struct packed {
        logic arw;
        logic at_min;
        logic at_max;
    } pid_flags_t;

    // Bound a wide value into [lo, hi].
    function automatic acc_t clip(input acc_t v, input acc_t lo, input acc_t hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic acc_t dmax(input int w);
        return (acc_t'(1) <<< (w - 1)) - acc_t'(1);
    endfunction

    function automatic acc_t dmin(input int w);
        return -(acc_t'(1) <<< (w - 1));
    endfunction

endpackage

// File: rtl/pid_prescaler.sv
module pid_prescaler #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active_i,
    input  logic [CW-1:0] ncyc_i,
    output logic          step_o,
    output logic [CW-1:0] ncyc_eff_o
);
    logic [CW-1:0] cnt_q;

    assign ncyc_eff_o = (ncyc_i == '0) ? CW'(1) : ncyc_i;
    assign step_o     = active_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || !active_i) begin
            cnt_q <= '0;
        end else if (step_o) begin
            cnt_q <= ncyc_eff_o - CW'(1);
        end else begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // A step is never followed directly by another when N exceeds one.
    assert_step_spacing_R4: assert property (@(posedge clk) disable iff (rst)
        (step_o && ncyc_eff_o > CW'(1)) |=> !step_o);

endmodule

// File: rtl/pid_front.sv
module pid_front
    import pid_fx_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 8
) (
    input  logic                 direct_i,
    input  logic                 mode_i,
    input  logic signed [DW-1:0] setp_i,
    input  logic signed [DW-1:0] meas_i,
    input  logic signed [GW-1:0] kp_i,
    output logic signed [DW-1:0] dev_o,
    output logic signed [DW-1:0] p_o,
    output logic signed [DW-1:0] u_o
);
    localparam acc_t DMAX = dmax(DW);
    localparam acc_t DMIN = dmin(DW);

    acc_t      diff;
    acc_t      prod;
    pid_mode_e mode;

    always_comb begin
        mode  = pid_mode_e'(mode_i);
        diff  = direct_i ? (acc_t'(meas_i) - acc_t'(setp_i))
                         : (acc_t'(setp_i) - acc_t'(meas_i));
        dev_o = DW'(clip(diff, DMIN, DMAX));
        prod  = (acc_t'(kp_i) * acc_t'(dev_o)) >>> FRAC;
        p_o   = DW'(clip(prod, DMIN, DMAX));
        u_o   = (mode == MODE_PARALLEL) ? dev_o : p_o;
    end

endmodule

// File: rtl/pid_integ.sv
module pid_integ
    import pid_fx_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 step_i,
    input  logic [TW-1:0]        tn_i,
    input  logic [CW-1:0]        ncyc_i,
    input  logic signed [DW-1:0] u_i,
    input  logic                 hold_i,
    input  logic                 load_i,
    input  acc_t                 load_val_i,
    output logic signed [DW-1:0] i_next_o
);
    localparam acc_t DMAX = dmax(DW);
    localparam acc_t DMIN = dmin(DW);

    logic signed [DW-1:0] i_q;
    acc_t den, incr, sum;

    always_comb begin
        den  = (tn_i == '0) ? acc_t'(1) : acc_t'(tn_i);
        incr = clip((acc_t'(u_i) * acc_t'(ncyc_i)) / den, DMIN, DMAX);
        sum  = clip(acc_t'(i_q) + incr, DMIN, DMAX);
        if (load_i)
            i_next_o = DW'(clip(load_val_i, DMIN, DMAX));
        else if (tn_i == '0)
            i_next_o = '0;
        else if (hold_i)
            i_next_o = i_q;
        else
            i_next_o = DW'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) i_q <= '0;
        else if (step_i)    i_q <= i_next_o;
    end

    // Anti-windup hold freezes the integral state.
    assert_hold_freezes_R9: assert property (@(posedge clk) disable iff (rst)
        (step_i && hold_i && !load_i && !clear_i && tn_i != '0) |=> (i_q == $past(i_q)));

endmodule

// File: rtl/pid_deriv.sv
module pid_deriv
    import pid_fx_pkg::*;
#(
    parameter int DW = 16,
    parameter int TW = 16,
    parameter int CW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear_i,
    input  logic                 step_i,
    input  logic                 first_i,
    input  logic [TW-1:0]        tv_i,
    input  logic [TW-1:0]        td_i,
    input  logic [CW-1:0]        ncyc_i,
    input  logic signed [DW-1:0] u_i,
    input  logic                 load_i,
    input  acc_t                 load_val_i,
    output logic signed [DW-1:0] d_next_o
);
    localparam acc_t DMAX = dmax(DW);
    localparam acc_t DMIN = dmin(DW);

    logic signed [DW-1:0] d_q;
    logic signed [DW-1:0] uprev_q;
    acc_t du, num, den;

    always_comb begin
        du  = first_i ? acc_t'(0) : (acc_t'(u_i) - acc_t'(uprev_q));
        num = acc_t'(td_i) * acc_t'(d_q) + acc_t'(tv_i) * du;
        den = acc_t'(td_i) + acc_t'(ncyc_i);
        if (load_i)
            d_next_o = DW'(clip(load_val_i, DMIN, DMAX));
        else if (tv_i == '0)
            d_next_o = '0;
        else
            d_next_o = DW'(clip(num / den, DMIN, DMAX));
    end

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            d_q     <= '0;
            uprev_q <= '0;
        end else if (step_i) begin
            d_q     <= d_next_o;
            uprev_q <= u_i;
        end
    end

    // A disabled derivative path leaves zero state behind.
    assert_d_disabled_R10: assert property (@(posedge clk) disable iff (rst)
        (step_i && !clear_i && !load_i && tv_i == '0) |=> (d_q == '0));

endmodule

// File: rtl/pid_fx_ctrl.sv
module pid_fx_ctrl
    import pid_fx_pkg::*;
#(
    parameter int DW   = 16,
    parameter int GW   = 16,
    parameter int FRAC = 8,
    parameter int TW   = 16,
    parameter int CW   = 8,
    parameter int EW   = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_i,
    input  logic                 direct_i,
    input  logic                 sync_i,
    input  logic signed [DW-1:0] sync_val_i,
    input  logic signed [DW-1:0] setp_i,
    input  logic signed [DW-1:0] meas_i,
    input  logic signed [GW-1:0] kp_i,
    input  logic [TW-1:0]        tn_i,
    input  logic [TW-1:0]        tv_i,
    input  logic [TW-1:0]        td_i,
    input  logic signed [DW-1:0] ymin_i,
    input  logic signed [DW-1:0] ymax_i,
    input  logic                 mode_i,
    input  logic [CW-1:0]        ncyc_i,
    output logic signed [DW-1:0] y_o,
    output logic signed [DW-1:0] dev_o,
    output logic                 arw_o,
    output logic                 at_min_o,
    output logic                 at_max_o,
    output logic                 err_o,
    output logic [EW-1:0]        err_code_o
);
    logic                 err_c, active, step, first_q, sync_q, edge_c, hold;
    logic [CW-1:0]        ncyc_eff;
    logic signed [DW-1:0] dev_c, p_c, u_c, i_next, d_next, y_c;
    acc_t                 s_tgt, i_load_val, d_load_val;
    pid_flags_t           flags_c;

    assign err_c  = (ymin_i >= ymax_i);
    assign active = en_i && !err_c;
    assign edge_c = sync_i && !sync_q;

    pid_prescaler #(.CW(CW)) u_presc (
        .clk(clk), .rst(rst), .active_i(active), .ncyc_i(ncyc_i),
        .step_o(step), .ncyc_eff_o(ncyc_eff)
    );

    pid_front #(.DW(DW), .GW(GW), .FRAC(FRAC)) u_front (
        .direct_i(direct_i), .mode_i(mode_i), .setp_i(setp_i), .meas_i(meas_i),
        .kp_i(kp_i), .dev_o(dev_c), .p_o(p_c), .u_o(u_c)
    );

    always_comb begin
        hold       = (tn_i != '0) &&
                     ((at_max_o && dev_c > 0) || (at_min_o && dev_c < 0));
        s_tgt      = clip(acc_t'(sync_val_i), acc_t'(ymin_i), acc_t'(ymax_i));
        d_load_val = s_tgt - acc_t'(p_c);
        i_load_val = s_tgt - acc_t'(p_c) - acc_t'(d_next);
    end

    pid_deriv #(.DW(DW), .TW(TW), .CW(CW)) u_deriv (
        .clk(clk), .rst(rst), .clear_i(!active), .step_i(step), .first_i(first_q),
        .tv_i(tv_i), .td_i(td_i), .ncyc_i(ncyc_eff), .u_i(u_c),
        .load_i(edge_c && tn_i == '0), .load_val_i(d_load_val), .d_next_o(d_next)
    );

    pid_integ #(.DW(DW), .TW(TW), .CW(CW)) u_integ (
        .clk(clk), .rst(rst), .clear_i(!active), .step_i(step), .tn_i(tn_i),
        .ncyc_i(ncyc_eff), .u_i(u_c), .hold_i(hold),
        .load_i(edge_c && tn_i != '0), .load_val_i(i_load_val), .i_next_o(i_next)
    );

    always_comb begin
        y_c            = DW'(clip(acc_t'(p_c) + acc_t'(i_next) + acc_t'(d_next),
                                  acc_t'(ymin_i), acc_t'(ymax_i)));
        flags_c.arw    = hold && !edge_c;
        flags_c.at_min = (y_c == ymin_i);
        flags_c.at_max = (y_c == ymax_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o      <= 1'b0;
            err_code_o <= EW'(ERR_NONE);
        end else begin
            err_o      <= err_c;
            err_code_o <= err_c ? EW'(ERR_LIMITS) : EW'(ERR_NONE);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            y_o      <= '0;
            dev_o    <= '0;
            arw_o    <= 1'b0;
            at_min_o <= 1'b0;
            at_max_o <= 1'b0;
            first_q  <= 1'b1;
            sync_q   <= 1'b0;
        end else if (step) begin
            y_o      <= y_c;
            dev_o    <= dev_c;
            arw_o    <= flags_c.arw;
            at_min_o <= flags_c.at_min;
            at_max_o <= flags_c.at_max;
            first_q  <= 1'b0;
            sync_q   <= sync_i;
        end
    end

    // Passive ticks leave every output at zero.
    assert_passive_zero_R2: assert property (@(posedge clk) disable iff (rst)
        !active |=> (y_o == '0 && dev_o == '0 && !arw_o && !at_min_o && !at_max_o));

    // Inconsistent limits are reported one edge later.
    assert_limit_error_R3: assert property (@(posedge clk) disable iff (rst)
        err_c |=> (err_o && err_code_o != '0));

    // Stepped output sits within the limits in force at the step.
    assert_output_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        step |=> (y_o >= $past(ymin_i) && y_o <= $past(ymax_i)));

    // Both limit flags never stand together.
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({at_min_o, at_max_o}));

endmodule

// File: tb/pid_fx_ctrl_tb_top.sv
`timescale 1ns/1ps
module pid_fx_ctrl_tb_top;
    logic               clk = 1'b0;
    logic               rst;
    logic               en, direct, sync, mode;
    logic signed [15:0] sync_val, setp, meas, kp, ymin, ymax;
    logic [15:0]        tn, tv, td;
    logic [7:0]         ncyc;
    logic signed [15:0] y, dev;
    logic               arw, at_min, at_max, err;
    logic [3:0]         err_code;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    bit saw_arw = 0, saw_min = 0, saw_max = 0;

    // model state
    longint m_i, m_d, m_up, m_y, m_e;
    int     m_cnt;
    bit     m_first, m_syncq, m_arw, m_amin, m_amax, m_err;

    always #2.5 clk = ~clk;

    pid_fx_ctrl dut_i (
        .clk(clk), .rst(rst), .en_i(en), .direct_i(direct), .sync_i(sync),
        .sync_val_i(sync_val), .setp_i(setp), .meas_i(meas), .kp_i(kp),
        .tn_i(tn), .tv_i(tv), .td_i(td), .ymin_i(ymin), .ymax_i(ymax),
        .mode_i(mode), .ncyc_i(ncyc), .y_o(y), .dev_o(dev), .arw_o(arw),
        .at_min_o(at_min), .at_max_o(at_max), .err_o(err), .err_code_o(err_code)
    );

    function automatic longint lim(longint v, longint lo, longint hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    function automatic longint s16(longint v);
        return lim(v, -32768, 32767);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_i = 0; m_d = 0; m_up = 0; m_y = 0; m_e = 0; m_cnt = 0;
        m_first = 1; m_syncq = 0; m_arw = 0; m_amin = 0; m_amax = 0; m_err = 0;
    endtask

    // One base tick of the reference model, using the inputs now applied.
    task automatic model_tick();
        longint e, p, u, dc, ic, s, inew, dnew, n, du;
        bit     edge_s, hold;
        m_err = (ymin >= ymax);
        if (!en || m_err) begin
            m_i = 0; m_d = 0; m_up = 0; m_y = 0; m_e = 0; m_cnt = 0;
            m_first = 1; m_syncq = 0; m_arw = 0; m_amin = 0; m_amax = 0;
            return;
        end
        n = (ncyc == 0) ? 1 : ncyc;
        if (m_cnt != 0) begin
            m_cnt = m_cnt - 1;
            return;
        end
        m_cnt  = int'(n) - 1;
        e      = s16(direct ? longint'(meas) - longint'(setp) : longint'(setp) - longint'(meas));
        p      = s16((longint'(kp) * e) >>> 8);
        u      = mode ? e : p;
        edge_s = sync && !m_syncq;
        m_syncq = sync;
        du     = m_first ? 0 : u - m_up;
        dc     = (tv == 0) ? 0 : s16((longint'(td) * m_d + longint'(tv) * du) / (longint'(td) + n));
        hold   = (tn != 0) && ((m_amax && e > 0) || (m_amin && e < 0));
        if (tn == 0) ic = 0;
        else if (hold) ic = m_i;
        else ic = s16(m_i + s16((u * n) / longint'(tn)));
        s = lim(sync_val, ymin, ymax);
        inew = ic; dnew = dc;
        if (edge_s) begin
            if (tn != 0) inew = s16(s - p - dc);
            else         dnew = s16(s - p);
        end
        m_arw  = hold && !edge_s;
        m_y    = lim(p + inew + dnew, ymin, ymax);
        m_amin = (m_y == ymin);
        m_amax = (m_y == ymax);
        m_e    = e;
        m_i = inew; m_d = dnew; m_up = u; m_first = 0;
    endtask

    task automatic check_all(string req);
        chk(req, "y", y, m_y);
        chk(req, "dev", dev, m_e);
        chk(req, "flags", {arw, at_min, at_max}, {m_arw, m_amin, m_amax});
        chk(req, "err", {err, err_code}, {m_err, m_err ? 4'd1 : 4'd0});
        if (arw) saw_arw = 1;
        if (at_min) saw_min = 1;
        if (at_max) saw_max = 1;
    endtask

    // Called at a falling edge with inputs set; returns at the next falling edge.
    task automatic run(int cycles, string req);
        for (int k = 0; k < cycles; k++) begin
            model_tick();
            @(negedge clk);
            check_all(req);
        end
    endtask

    task automatic base_setup();
        en = 1; direct = 1; sync = 0; mode = 1; sync_val = 0;
        setp = 0; meas = 0; kp = 16'sd256; tn = 0; tv = 0; td = 0;
        ymin = -16'sd5000; ymax = 16'sd5000; ncyc = 1;
    endtask

    task automatic randomize_inputs();
        int r;
        setp = 16'($signed($urandom_range(0, 6000)) - 3000);
        meas = 16'($signed($urandom_range(0, 6000)) - 3000);
        if ($urandom_range(0, 7) == 0) begin
            kp   = 16'($signed($urandom_range(0, 928)) - 128);
            mode = 1'($urandom_range(0, 1));
            r    = $urandom_range(0, 40);
            tn   = ($urandom_range(0, 4) == 0) ? 16'd0 : 16'(r);
            tv   = ($urandom_range(0, 2) == 0) ? 16'd0 : 16'($urandom_range(1, 20));
            td   = 16'($urandom_range(0, 30));
            ncyc = 8'($urandom_range(0, 4));
            ymin = 16'(-$signed($urandom_range(0, 2000)));
            ymax = 16'($urandom_range(0, 2000));
            if ($urandom_range(0, 19) == 0) ymax = ymin;
        end
        direct   = ($urandom_range(0, 9) != 0) ? direct : ~direct;
        en       = ($urandom_range(0, 49) != 0);
        sync     = ($urandom_range(0, 9) == 0) ? ~sync : sync;
        sync_val = 16'($signed($urandom_range(0, 6000)) - 3000);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        base_setup();
        en = 0;
        rst = 1;
        model_reset();
        repeat (3) @(negedge clk);
        check_all("R2");                        // reset state, R2
        rst = 0;
        base_setup();

        // R1: direct then reverse action
        meas = 16'sd100; setp = 16'sd40;
        run(3, "R1");
        chk("R1", "dev direct", dev, 60);
        direct = 0;
        run(3, "R1");
        chk("R1", "dev reverse", dev, -60);

        // R6 parallel, R7 series, with integral and derivative
        kp = 16'sd512; tn = 5; tv = 3; td = 2;
        run(6, "R6");
        mode = 0;
        run(6, "R7");

        // R8: integral disabled versus active
        tn = 0; tv = 0;
        run(3, "R8");
        tn = 7; meas = -16'sd300;
        run(5, "R8");

        // R9: wind into upper limit, keep deviation positive, then reverse
        en = 0; run(1, "R2");
        base_setup(); tn = 1; meas = 16'sd500; ymin = -16'sd1000; ymax = 16'sd1000;
        run(10, "R9");
        chk("R9", "arw seen", saw_arw, 1);
        chk("R5", "upper limit flag seen", saw_max, 1);
        direct = 0;
        run(12, "R9");
        chk("R5", "lower limit flag seen", saw_min, 1);

        // R10: filtered derivative with changing measurement
        en = 0; run(1, "R12");
        base_setup(); tv = 4; td = 3;
        for (int k = 0; k < 8; k++) begin
            meas = 16'(k * 37 - 100);
            run(1, "R10");
        end

        // R4: call-cycle divider of 3, then 0 acting as 1
        ncyc = 3; tn = 4;
        for (int k = 0; k < 9; k++) begin
            meas = 16'(k * 50);
            run(1, "R4");
        end
        ncyc = 0;
        run(4, "R4");

        // R11: sync above the upper limit, then held high, then with I off
        ncyc = 1; ymax = 16'sd800; sync_val = 16'sd3000; sync = 1;
        run(1, "R11");
        chk("R11", "sync to clamped target", y, 800);
        run(3, "R11");
        sync = 0; run(1, "R11");
        tn = 0; sync_val = -16'sd200; sync = 1;
        run(3, "R11");

        // R12: re-enable with sync already high
        en = 0; run(2, "R12");
        en = 1; sync_val = 16'sd150; tn = 6; tv = 2;
        run(4, "R12");

        // R3: inconsistent limits force passive
        sync = 0; ymin = 16'sd100; ymax = 16'sd100;
        run(3, "R3");
        chk("R3", "err flag", err, 1);
        ymin = -16'sd100;
        run(2, "R3");

        // Mixed random traffic, R5 overall
        for (int k = 0; k < 6000; k++) begin
            randomize_inputs();
            run(1, "R5");
        end

        finish_run();
    end
endmodule